// File: doc/BRIEF.md
# Two-Button Stopwatch Controller with Lap Hold

This block is the control core of a stopwatch and its elapsed-time counter. It is driven by a system clock and a one-millisecond count-enable tick. Two debounced button pulses, each one clock cycle long, are its only other inputs. One button starts and stops the watch. The other takes a lap split while the watch runs, and clears the watch while it is stopped.

A five-state Moore machine produces three control lines: clear, run and load. The run line gates the tick into a chain of five BCD digits. The load line copies the four least significant digits into a display holding register. In the lap state that register stays frozen while the count keeps running underneath, so the split time can be read at leisure.

Clock division, button debouncing and display multiplexing are handled elsewhere.

Top module: `chrono_ctrl`

## Requirements
- R1: A synchronous active-high `rst` forces the initial state whatever the buttons do. The clock edge that samples `rst` high sets `count_val` and `disp_val` to zero, and the controls then read clear=1, run=0, load=1.
- R2: The initial state drives clear=1, run=0, load=1. It lasts exactly one cycle and always moves to the stopped state, ignoring both buttons.
- R3: The stopped state drives clear=0, run=0, load=0. While stopped, ticks do not change `count_val` and `disp_val` does not change.
- R4: The running state drives clear=0, run=1, load=1. Each cycle with `tick_ms` high adds one to the count. After every edge taken in this state, `disp_val` equals the low 16 bits of `count_val`.
- R5: Each 4-bit digit of `count_val` (digit k in bits 4k+3..4k) counts 0 to 9. It wraps to 0 and carries into the next digit. The top digit wraps from 99999 to 00000 with no overflow indication.
- R6: A lap press while running enters a pre-lap state for exactly one cycle (clear=0, run=1, load=0), then the lap state. `disp_val` keeps the count reached at the press edge, and counting goes on.
- R7: The lap state drives clear=0, run=1, load=0, so `disp_val` stays frozen while `count_val` advances. A start/stop press returns to running. A lap press passes through pre-lap back to lap.
- R8: A start/stop press moves stopped to running and running to stopped.
- R9: A lap press while stopped moves to the initial state, which clears the count and shows zero.
- R10: When both buttons are pressed in the same cycle, start/stop wins in the stopped, running and lap states.
- R11: The three control outputs depend only on the current state, never directly on an input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle count-enable pulse at 1 kHz |
| btn_go | input | 1 | Start/stop button pulse, one cycle |
| btn_lap | input | 1 | Lap/reset button pulse, one cycle |
| ctl_clear | output | 1 | Counter clear control |
| ctl_run | output | 1 | Counter enable control |
| ctl_load | output | 1 | Display register load control |
| count_val | output | 20 | Live elapsed count, five BCD digits |
| disp_val | output | 16 | Display holding register, four BCD digits |

## Verification
Two pairs of functions can fall in the same cycle. In the first, both button pulses are raised on one cycle while running, so the start/stop priority and the pre-lap path compete. In the second, a tick lands on the same edge where the display register loads, so the counter increment and the display capture act together. The bench keeps ticks running while the buttons are pressed and raises both buttons at once. A behavioural model of states, a decimal count and a display value is compared on every clock against the outputs. That comparison decides whether the display took the count as it stands after that edge and whether the losing button was ignored.

// File: rtl/chrono_pkg.sv
package chrono_pkg;

    typedef enum logic [2:0] {
        ST_INIT = 3'd0,
        ST_HALT = 3'd1,
        ST_RUN  = 3'd2,
        ST_PRE  = 3'd3,
        ST_LAP  = 3'd4
    } sw_state_e;

    typedef struct packed {
        logic clr;
        logic en;
        logic ld;
    } sw_ctl_t;

    typedef struct packed {
        sw_state_e st;
    } fsm_regs_t;

endpackage

// File: rtl/chrono_fsm.sv
module chrono_fsm
    import chrono_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    go_i,
    input  logic    lap_i,
    output sw_ctl_t ctl_o
);

    fsm_regs_t r_d, r_q;

    // next-state logic; start/stop is tested before lap/reset everywhere
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_INIT: r_d.st = ST_HALT;
            ST_HALT: begin
                if (go_i)       r_d.st = ST_RUN;
                else if (lap_i) r_d.st = ST_INIT;
            end
            ST_RUN: begin
                if (go_i)       r_d.st = ST_HALT;
                else if (lap_i) r_d.st = ST_PRE;
            end
            ST_PRE:  r_d.st = ST_LAP;
            ST_LAP: begin
                if (go_i)       r_d.st = ST_RUN;
                else if (lap_i) r_d.st = ST_PRE;
            end
            default: r_d.st = ST_INIT;
        endcase
        if (rst) r_d.st = ST_INIT;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    // Moore decode, all outputs defaulted
    always_comb begin
        ctl_o = '0;
        case (r_q.st)
            ST_INIT: begin ctl_o.clr = 1'b1; ctl_o.ld = 1'b1; end
            ST_RUN:  begin ctl_o.en  = 1'b1; ctl_o.ld = 1'b1; end
            ST_PRE:  ctl_o.en = 1'b1;
            ST_LAP:  ctl_o.en = 1'b1;
            default: ctl_o = '0;
        endcase
    end

    AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_INIT) |=> (r_q.st == ST_HALT)); // R2
    AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_PRE) |=> (r_q.st == ST_LAP)); // R6
    AST_GO_WINS_RUN: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_RUN && go_i && lap_i) |=> (r_q.st == ST_HALT)); // R10
    AST_LAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_HALT && lap_i && !go_i) |=> ctl_o.clr); // R9

endmodule

// File: rtl/chrono_bcd_count.sv
module chrono_bcd_count #(
    parameter int NDIG  = 5,
    parameter int NDISP = 4,
    localparam int CW   = 4 * NDIG,
    localparam int DW   = 4 * NDISP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic [DW-1:0] nxt_low_o
);

    localparam logic [CW-1:0] ALL_NINE = {NDIG{4'd9}};

    logic [NDIG-1:0] cin;
    assign cin[0] = inc_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [3:0] dig_d, dig_q;

        always_comb begin
            dig_d = dig_q;
            if (rst || clr_i)      dig_d = 4'd0;
            else if (cin[g])       dig_d = (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
        end

        always_ff @(posedge clk) begin
            dig_q <= dig_d;
        end

        assign cnt_o[4*g +: 4] = dig_q;

        if (g < NDIG - 1) begin : g_carry
            assign cin[g+1] = cin[g] && (dig_q == 4'd9);
        end
        if (g < NDISP) begin : g_low
            assign nxt_low_o[4*g +: 4] = dig_d;
        end

        AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
            dig_q <= 4'd9); // R5
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !inc_i) |=> $stable(cnt_o)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i && cnt_o == ALL_NINE) |=> (cnt_o == '0)); // R5

endmodule

// File: rtl/chrono_ctrl.sv
module chrono_ctrl #(
    parameter int NDIG  = 5,
    parameter int NDISP = 4,
    localparam int CW   = 4 * NDIG,
    localparam int DW   = 4 * NDISP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_ms,
    input  logic          btn_go,
    input  logic          btn_lap,
    output logic          ctl_clear,
    output logic          ctl_run,
    output logic          ctl_load,
    output logic [CW-1:0] count_val,
    output logic [DW-1:0] disp_val
);
    import chrono_pkg::*;

    sw_ctl_t       ctl;
    logic [DW-1:0] nxt_low;
    logic [DW-1:0] disp_d, disp_q;

    chrono_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .go_i  (btn_go),
        .lap_i (btn_lap),
        .ctl_o (ctl)
    );

    chrono_bcd_count #(.NDIG(NDIG), .NDISP(NDISP)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (ctl.clr),
        .inc_i     (ctl.en && tick_ms),
        .cnt_o     (count_val),
        .nxt_low_o (nxt_low)
    );

    // display holding register takes the value the count holds after this edge
    always_comb begin
        disp_d = disp_q;
        if (rst)         disp_d = '0;
        else if (ctl.ld) disp_d = nxt_low;
    end

    always_ff @(posedge clk) begin
        disp_q <= disp_d;
    end

    assign disp_val  = disp_q;
    assign ctl_clear = ctl.clr;
    assign ctl_run   = ctl.en;
    assign ctl_load  = ctl.ld;

    AST_DISP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ctl_load |=> $stable(disp_val)); // R7
    AST_DISP_TRACKS: assert property (@(posedge clk) disable iff (rst)
        ctl_load |=> (disp_val == count_val[DW-1:0])); // R4
    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (count_val == '0 && disp_val == '0)); // R1

endmodule

// File: tb/sim_chrono_ctrl.sv
module sim_chrono_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_ms = 1'b0;
    logic        btn_go = 1'b0;
    logic        btn_lap = 1'b0;
    logic        ctl_clear, ctl_run, ctl_load;
    logic [19:0] count_val;
    logic [15:0] disp_val;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    armed  = 1'b0;
    bit    done   = 1'b0;
    string phase  = "R1";

    // reference model: 0 init, 1 stopped, 2 running, 3 pre-lap, 4 lap
    int m_st = 0;
    int m_cnt = 0;
    int m_disp = 0;

    always #5 clk = ~clk;

    chrono_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_ms   (tick_ms),
        .btn_go    (btn_go),
        .btn_lap   (btn_lap),
        .ctl_clear (ctl_clear),
        .ctl_run   (ctl_run),
        .ctl_load  (ctl_load),
        .count_val (count_val),
        .disp_val  (disp_val)
    );

    function automatic logic [31:0] to_bcd(input int v, input int nd);
        logic [31:0] r = '0;
        for (int i = 0; i < nd; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_disp = 0;
        end else begin
            if (m_st == 0)                     m_cnt = 0;
            else if (m_st >= 2 && tick_ms)     m_cnt = (m_cnt + 1) % 100000;
            if (m_st == 0 || m_st == 2)        m_disp = m_cnt % 10000;
            case (m_st)
                0: m_st = 1;
                1: m_st = btn_go ? 2 : (btn_lap ? 0 : 1);
                2: m_st = btn_go ? 1 : (btn_lap ? 3 : 2);
                3: m_st = 4;
                4: m_st = btn_go ? 2 : (btn_lap ? 3 : 4);
                default: m_st = 0;
            endcase
        end
        armed = 1'b1;
    end

    // compare away from the active edge, every cycle
    always @(negedge clk) begin
        if (armed && !done) begin
            chk(ctl_clear == (m_st == 0), "R11", "clear", 32'(ctl_clear), 32'(m_st == 0));
            chk(ctl_run == (m_st >= 2), "R11", "run", 32'(ctl_run), 32'(m_st >= 2));
            chk(ctl_load == (m_st == 0 || m_st == 2), "R11", "load",
                32'(ctl_load), 32'(m_st == 0 || m_st == 2));
            chk(32'(count_val) == to_bcd(m_cnt, 5), phase, "count", 32'(count_val), to_bcd(m_cnt, 5));
            chk(32'(disp_val) == to_bcd(m_disp, 4), phase, "display", 32'(disp_val), to_bcd(m_disp, 4));
        end
    end

    task automatic cyc(input logic g, input logic l, input logic t);
        @(negedge clk);
        btn_go = g; btn_lap = l; tick_ms = t;
    endtask

    task automatic ticks(input int n, input int every);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, (i % every) == 0);
    endtask

    initial begin : watchdog
        wait (cycles > 190000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        // R1: reset wins over a held start/stop button
        phase = "R1";
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(ctl_clear && !ctl_run && ctl_load, "R1", "controls in reset",
            {29'd0, ctl_clear, ctl_run, ctl_load}, 32'd5);
        chk(count_val == 20'd0 && disp_val == 16'd0, "R1", "zero values",
            32'(count_val), 32'd0);
        // R2: release reset while pressing start; init ignores it
        phase = "R2";
        rst = 1'b0;
        btn_go = 1'b1; btn_lap = 1'b0; tick_ms = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
        chk(!ctl_run && !ctl_clear && !ctl_load, "R2", "stopped after init",
            {29'd0, ctl_clear, ctl_run, ctl_load}, 32'd0);
        // R3: ticks while stopped change nothing
        phase = "R3";
        ticks(12, 1);
        chk(count_val == 20'd0, "R3", "count held", 32'(count_val), 32'd0);
        // R8: start, R4: run with mixed tick spacing
        phase = "R8";
        cyc(1'b1, 1'b0, 1'b1);
        phase = "R4";
        ticks(40, 1);
        ticks(30, 3);
        ticks(25, 2);
        // R6: lap press while a tick lands in the same cycle
        phase = "R6";
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        held = disp_val;
        // R7: display frozen in lap, count advances
        phase = "R7";
        ticks(30, 1);
        chk(disp_val == held, "R7", "frozen split", 32'(disp_val), 32'(held));
        chk(count_val[15:0] != held, "R7", "count moved", 32'(count_val), 32'(held));
        cyc(1'b0, 1'b1, 1'b1);
        ticks(10, 1);
        chk(disp_val == held, "R7", "split after relap", 32'(disp_val), 32'(held));
        cyc(1'b1, 1'b0, 1'b1);
        ticks(15, 1);
        // R10: both buttons while running -> stopped
        phase = "R10";
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        chk(!ctl_run && !ctl_load, "R10", "stopped wins", {30'd0, ctl_run, ctl_load}, 32'd0);
        ticks(5, 1);
        // R10 in stopped and lap states as well
        cyc(1'b1, 1'b1, 1'b0);
        ticks(6, 1);
        cyc(1'b0, 1'b1, 1'b1);
        ticks(4, 1);
        cyc(1'b1, 1'b1, 1'b1);
        ticks(4, 1);
        cyc(1'b1, 1'b0, 1'b0);
        ticks(3, 1);
        // R9: lap while stopped clears
        phase = "R9";
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk(count_val == 20'd0 && disp_val == 16'd0, "R9", "cleared", 32'(count_val), 32'd0);
        // R5: full range, digit carries and final wrap
        phase = "R5";
        cyc(1'b1, 1'b0, 1'b0);
        ticks(100000, 1);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk(count_val == 20'h00001, "R5", "wrapped past 99999", 32'(count_val), 32'h1);
        ticks(4, 1);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule